// File: doc/BRIEF.md
# Register-Mapped I2C Host Front-End

This block is the processor-facing half of an I2C host controller. A simple request/ready register bus reaches five byte-wide registers: a storage-only own-address register, a storage-only clock-divider register, a control register, a status register and a data register. Behind the block sits a byte-level transaction engine. The engine accepts four requests: start-and-address, send-byte, receive-byte and end-transfer. Each request uses a req/done handshake and returns an acknowledge flag, and a receive also returns a data byte.

Software drives the bus through the data register. A data write made while no target is open sends the address byte, and a later write sends a payload byte. Each data read returns the byte that the previous read captured, and in the same access fetches the next byte from the bus. The register bus is held through `bus_ready` until the engine has finished whatever a data-register access or a control write started. The control register also handles enable, soft reset, host mode with the bus-busy flag, and repeated start. The status register holds acknowledge tracking and a level interrupt whose flags are cleared by writing zero.

Top module: `i2c_host_regs`

## Requirements
- R1: Register offsets are 0 own-address (bits 7:1 stored, bit 0 reads 0), 1 divider (bits 5:0 stored), 2 control, 3 status, 4 data. All of them reset to 0. Only the low 8 bits of write data are used. Offsets 5 to 7 read as 0 and writes to them change nothing.
- R2: Control bits are 7 enable, 6 interrupt enable, 5 host mode, 4 transmit direction, 3 acknowledge control (stored only) and 2 repeated start. Bits 1:0 read as 0.
- R3: A normal control write with host mode 1 sets status bit 5 (bus busy). With host mode 0 it clears bus busy, and if a target is open it issues an end-transfer request (engine op 3) and closes the target.
- R4: A control write with repeated start 1 while host mode stays 1 and a target is open issues end-transfer and closes the target, and the repeated-start bit then reads 0. If no target is open, the bit is stored as written.
- R5: A control write with enable 0 while enable is 1 is a soft reset. Divider, control, status and the data read buffer return to 0. Own-address keeps its value. An open target is ended with op 3.
- R6: Status bit 1 (interrupt pending) is set, and `irq` goes high, only on a successful address, send or receive while control enable and interrupt enable are both 1. `irq` equals status bit 1.
- R7: A status write clears bit 1 (pending) and bit 4 (arbitration lost) only where the written bit is 0. Writing 1 leaves them unchanged.
- R8: Data-register writes while enable is 0, or while host mode is 0, issue no engine request and change no state.
- R9: A data write in host mode with no open target issues op 0 with the byte (bits 7:1 address, bit 0 direction). On NACK, status bit 0 (no-acknowledge) is set and no target opens. On ACK, the target opens, bit 0 clears and an interrupt is raised.
- R10: A data write with an open target issues op 1. On ACK, bit 0 clears and an interrupt is raised. On NACK, bit 0 is set and op 3 is issued before the access completes, which closes the target.
- R11: A data read returns the byte stored by the previous read. If host mode is 1, a target is open and transmit direction is 0, the read issues op 2 and stores the returned byte with an interrupt. On a failed receive it stores 0xFF with no interrupt. Otherwise it stores 0xFF without any request.
- R12: `bus_ready` is high only while `bus_sel` is high. It stays low until the engine's done ends every request the access started. `eng_req` and `eng_op` hold until `eng_done`. Plain register accesses complete in their first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access request, held until ready |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 16 | Write data (low byte used) |
| bus_rdata | output | 16 | Read data, valid with ready |
| bus_ready | output | 1 | Access completes this cycle |
| irq | output | 1 | Level interrupt |
| eng_req | output | 1 | Engine request, held until done |
| eng_op | output | 2 | 0 start, 1 send, 2 receive, 3 end |
| eng_wdata | output | 8 | Address or payload byte |
| eng_done | input | 1 | Engine completion pulse |
| eng_ack | input | 1 | Acknowledge / receive success |
| eng_rdata | input | 8 | Received byte |

## Verification
The hardest case to reach is a payload NACK. It has to chain a second engine request (end-transfer) inside one stalled bus access, and the loss of the open target shows only in the opcode of the next data write. The engine model in the bench NACKs a chosen byte value and records every opcode and the end-transfer count. Directed sequences and a seeded random sequence of sends, reads and flag clears then open targets, lose them and reopen them. The prefetching read buffer is the second hard case. The bench tracks it across failed receives, reads with the transmit direction set, and soft reset.

// File: rtl/i2ch_pkg.sv
// Package: shared encodings for the I2C host register front-end.
// Assumes byte-wide registers; offsets and bit positions are decoded
// by software and by the bench, so they are fixed here.
package i2ch_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ENG_START = 2'd0,
        ENG_SEND  = 2'd1,
        ENG_RECV  = 2'd2,
        ENG_STOP  = 2'd3
    } eng_op_e;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_ADDR, SQ_SEND, SQ_RECV, SQ_GAP, SQ_STOP
    } seq_e;

    localparam logic [2:0] OFS_OWN  = 3'd0;
    localparam logic [2:0] OFS_DIV  = 3'd1;
    localparam logic [2:0] OFS_CTRL = 3'd2;
    localparam logic [2:0] OFS_STAT = 3'd3;
    localparam logic [2:0] OFS_DATA = 3'd4;

    localparam int C_EN   = 7;
    localparam int C_IE   = 6;
    localparam int C_HOST = 5;
    localparam int C_TX   = 4;
    localparam int C_RSTA = 2;

    localparam int S_BUSY = 5;
    localparam int S_ARB  = 4;
    localparam int S_PEND = 1;
    localparam int S_NAK  = 0;

    localparam logic [BYTE_W-1:0] CTRL_MASK = 8'hFC;
    localparam logic [BYTE_W-1:0] OWN_MASK  = 8'hFE;
    localparam logic [BYTE_W-1:0] IDLE_BYTE = 8'hFF;
endpackage

// File: rtl/i2ch_eng_port.sv
// Module: engine request holder.
// Turns a one-cycle launch into a req that stays high, with a stable
// opcode and byte, until the engine pulses done. Assumes launch only
// arrives while no request is open.
module i2ch_eng_port
    import i2ch_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic [1:0]    launch_op,
    input  logic [DW-1:0] launch_byte,
    input  logic          eng_done,
    output logic          eng_req,
    output logic [1:0]    eng_op,
    output logic [DW-1:0] eng_wdata
);
    // Hold the request from launch until done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_req   <= 1'b0;
            eng_op    <= ENG_STOP;
            eng_wdata <= '0;
        end else if (launch) begin
            eng_req   <= 1'b1;
            eng_op    <= launch_op;
            eng_wdata <= launch_byte;
        end else if (eng_done) begin
            eng_req   <= 1'b0;
        end
    end

    // R12: request and opcode stay put until the engine answers
    p_req_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req && !eng_done |=> eng_req && $stable(eng_op) && $stable(eng_wdata));
    // R12: only one request open at a time
    p_one_open_r12: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> !eng_req);
endmodule

// File: rtl/i2ch_irq_flag.sv
// Module: interrupt-pending flag.
// Sets on a raise event only while enable and interrupt enable are
// both 1; clears on a zero-write or soft reset. The flag is the line.
module i2ch_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic raise,
    input  logic en,
    input  logic ie,
    input  logic clr,
    output logic pend
);
    // Keep the pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= 1'b0;
        else if (clr)
            pend <= 1'b0;
        else if (raise && en && ie)
            pend <= 1'b1;
    end

    // R6: the flag only rises on a permitted raise
    p_pend_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pend ##1 pend |-> $past(raise && en && ie));
    // R7: a clear always takes effect
    p_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !pend);
endmodule

// File: rtl/i2c_host_regs.sv
// Module: register-mapped I2C host front-end (top).
// Decodes register-bus accesses, keeps the register state, and turns
// data-register accesses and control writes into engine requests,
// stalling the bus until the engine is done. Assumes bus_sel is held
// until bus_ready and eng_done only pulses while eng_req is high.
module i2c_host_regs
    import i2ch_pkg::*;
#(
    parameter int BUS_AW = 3,
    parameter int BUS_DW = 16,
    parameter int DIV_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic              bus_ready,
    output logic              irq,
    output logic              eng_req,
    output logic [1:0]        eng_op,
    output logic [7:0]        eng_wdata,
    input  logic              eng_done,
    input  logic              eng_ack,
    input  logic [7:0]        eng_rdata
);
    localparam int BW = BYTE_W;

    seq_e            st_q, st_d;
    logic [BW-1:0]   own_q, own_d;
    logic [DIV_W-1:0] div_q, div_d;
    logic [BW-1:0]   ctrl_q, ctrl_d;
    logic [BW-1:0]   rdbuf_q, rdbuf_d;
    logic            busy_q, busy_d;
    logic            arb_q, arb_d;
    logic            nak_q, nak_d;
    logic            act_q, act_d;
    logic            pend;
    logic            launch, raise, pend_clr, stop_req;
    logic [1:0]      launch_op;
    logic [BW-1:0]   wv;
    logic [BW-1:0]   stat;
    logic [BUS_AW-1:0] ofs;

    assign wv  = bus_wdata[BW-1:0];
    assign ofs = bus_addr;
    assign irq = pend;

    // Assemble the status byte from its flags.
    always_comb begin
        stat         = '0;
        stat[S_BUSY] = busy_q;
        stat[S_ARB]  = arb_q;
        stat[S_PEND] = pend;
        stat[S_NAK]  = nak_q;
    end

    // Register read multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (ofs == BUS_AW'(OFS_OWN))       bus_rdata = BUS_DW'(own_q);
        else if (ofs == BUS_AW'(OFS_DIV))  bus_rdata = BUS_DW'(div_q);
        else if (ofs == BUS_AW'(OFS_CTRL)) bus_rdata = BUS_DW'(ctrl_q);
        else if (ofs == BUS_AW'(OFS_STAT)) bus_rdata = BUS_DW'(stat);
        else if (ofs == BUS_AW'(OFS_DATA)) bus_rdata = BUS_DW'(rdbuf_q);
    end

    // Access sequencer: next register values, engine launches, ready.
    always_comb begin
        st_d      = st_q;
        own_d     = own_q;
        div_d     = div_q;
        ctrl_d    = ctrl_q;
        rdbuf_d   = rdbuf_q;
        busy_d    = busy_q;
        arb_d     = arb_q;
        nak_d     = nak_q;
        act_d     = act_q;
        launch    = 1'b0;
        launch_op = ENG_STOP;
        raise     = 1'b0;
        pend_clr  = 1'b0;
        stop_req  = 1'b0;
        bus_ready = 1'b0;
        case (st_q)
            SQ_IDLE: if (bus_sel) begin
                if (bus_wr) begin
                    if (ofs == BUS_AW'(OFS_OWN)) begin
                        own_d = wv & OWN_MASK;
                    end else if (ofs == BUS_AW'(OFS_DIV)) begin
                        div_d = wv[DIV_W-1:0];
                    end else if (ofs == BUS_AW'(OFS_CTRL)) begin
                        if (ctrl_q[C_EN] && !wv[C_EN]) begin
                            div_d    = '0;
                            ctrl_d   = '0;
                            rdbuf_d  = '0;
                            busy_d   = 1'b0;
                            arb_d    = 1'b0;
                            nak_d    = 1'b0;
                            act_d    = 1'b0;
                            pend_clr = 1'b1;
                            stop_req = act_q;
                        end else begin
                            ctrl_d   = wv & CTRL_MASK;
                            busy_d   = wv[C_HOST];
                            stop_req = act_q && (!wv[C_HOST] || wv[C_RSTA]);
                            if (stop_req)
                                act_d = 1'b0;
                            if (act_q && wv[C_HOST] && wv[C_RSTA])
                                ctrl_d[C_RSTA] = 1'b0;
                        end
                    end else if (ofs == BUS_AW'(OFS_STAT)) begin
                        pend_clr = !wv[S_PEND];
                        if (!wv[S_ARB])
                            arb_d = 1'b0;
                    end else if (ofs == BUS_AW'(OFS_DATA)) begin
                        if (ctrl_q[C_EN] && ctrl_q[C_HOST]) begin
                            launch    = 1'b1;
                            launch_op = act_q ? ENG_SEND : ENG_START;
                            st_d      = act_q ? SQ_SEND : SQ_ADDR;
                        end
                    end
                end else if (ofs == BUS_AW'(OFS_DATA)) begin
                    if (ctrl_q[C_HOST] && act_q && !ctrl_q[C_TX]) begin
                        launch    = 1'b1;
                        launch_op = ENG_RECV;
                        st_d      = SQ_RECV;
                    end else begin
                        rdbuf_d = IDLE_BYTE;
                    end
                end
                if (stop_req) begin
                    launch    = 1'b1;
                    launch_op = ENG_STOP;
                    st_d      = SQ_STOP;
                end
                bus_ready = !launch;
            end
            SQ_ADDR: if (eng_done) begin
                bus_ready = 1'b1;
                st_d      = SQ_IDLE;
                if (eng_ack) begin
                    act_d = 1'b1;
                    nak_d = 1'b0;
                    raise = 1'b1;
                end else begin
                    nak_d = 1'b1;
                end
            end
            SQ_SEND: if (eng_done) begin
                if (eng_ack) begin
                    nak_d     = 1'b0;
                    raise     = 1'b1;
                    bus_ready = 1'b1;
                    st_d      = SQ_IDLE;
                end else begin
                    nak_d = 1'b1;
                    act_d = 1'b0;
                    st_d  = SQ_GAP;
                end
            end
            SQ_GAP: begin
                launch    = 1'b1;
                launch_op = ENG_STOP;
                st_d      = SQ_STOP;
            end
            SQ_STOP: if (eng_done) begin
                bus_ready = 1'b1;
                st_d      = SQ_IDLE;
            end
            SQ_RECV: if (eng_done) begin
                bus_ready = 1'b1;
                st_d      = SQ_IDLE;
                if (eng_ack) begin
                    rdbuf_d = eng_rdata;
                    raise   = 1'b1;
                end else begin
                    rdbuf_d = IDLE_BYTE;
                end
            end
            default: st_d = SQ_IDLE;
        endcase
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= SQ_IDLE;
            own_q   <= '0;
            div_q   <= '0;
            ctrl_q  <= '0;
            rdbuf_q <= '0;
            busy_q  <= 1'b0;
            arb_q   <= 1'b0;
            nak_q   <= 1'b0;
            act_q   <= 1'b0;
        end else begin
            st_q    <= st_d;
            own_q   <= own_d;
            div_q   <= div_d;
            ctrl_q  <= ctrl_d;
            rdbuf_q <= rdbuf_d;
            busy_q  <= busy_d;
            arb_q   <= arb_d;
            nak_q   <= nak_d;
            act_q   <= act_d;
        end
    end

    i2ch_eng_port #(.DW(BW)) u_eng_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (launch),
        .launch_op   (launch_op),
        .launch_byte (wv),
        .eng_done    (eng_done),
        .eng_req     (eng_req),
        .eng_op      (eng_op),
        .eng_wdata   (eng_wdata)
    );

    i2ch_irq_flag u_irq_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .raise (raise),
        .en    (ctrl_q[C_EN]),
        .ie    (ctrl_q[C_IE]),
        .clr   (pend_clr),
        .pend  (pend)
    );

    // R12: ready only answers a live access
    p_ready_sel_r12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |-> bus_sel);
    // R8: no start/send/receive request while disabled or not host
    p_no_req_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_req) && eng_op != ENG_STOP |-> ctrl_q[C_EN] && ctrl_q[C_HOST]);
    // R3: bus busy follows the host bit after a normal control write
    p_busy_host_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == SQ_IDLE && bus_sel && bus_wr && ofs == BUS_AW'(OFS_CTRL)
        && !(ctrl_q[C_EN] && !bus_wdata[C_EN])
        |=> busy_q == $past(bus_wdata[C_HOST]));
    // R5: soft reset keeps own-address and clears control
    p_soft_own_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == SQ_IDLE && bus_sel && bus_wr && ofs == BUS_AW'(OFS_CTRL)
        && ctrl_q[C_EN] && !bus_wdata[C_EN]
        |=> own_q == $past(own_q) && ctrl_q == '0);
    // R10: a refused payload byte closes the target and flags no-ack
    p_nack_close_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == SQ_SEND && eng_done && !eng_ack |=> !act_q && nak_q && eng_req == 1'b0);
endmodule

// File: tb/test_i2c_host_regs.sv
`timescale 1ns/1ps
module test_i2c_host_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_ready;
    logic        irq;
    logic        eng_req;
    logic [1:0]  eng_op;
    logic [7:0]  eng_wdata;
    logic        eng_done = 1'b0;
    logic        eng_ack = 1'b0;
    logic [7:0]  eng_rdata = '0;

    int checks = 0;
    int errors = 0;
    int op_cnt = 0;
    int stop_cnt = 0;
    int last_op = -1;
    logic [7:0] rx_next = 8'h40;
    logic       rx_fail = 1'b0;

    always #2.5 clk = ~clk;

    i2c_host_regs i_i2c_host_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .irq(irq), .eng_req(eng_req), .eng_op(eng_op),
        .eng_wdata(eng_wdata), .eng_done(eng_done), .eng_ack(eng_ack),
        .eng_rdata(eng_rdata)
    );

    // Engine model: target 0x50 answers, payload 0xEE is refused.
    initial begin
        forever begin
            @(negedge clk);
            if (eng_req && !eng_done) begin
                op_cnt++;
                last_op = int'(eng_op);
                if (eng_op == 2'd3) stop_cnt++;
                repeat (1 + $urandom % 3) @(negedge clk);
                case (eng_op)
                    2'd0: eng_ack = (eng_wdata[7:1] == 7'h50);
                    2'd1: eng_ack = (eng_wdata != 8'hEE);
                    2'd2: begin
                        eng_ack   = !rx_fail;
                        eng_rdata = rx_next;
                        if (!rx_fail) rx_next = rx_next + 8'd1;
                    end
                    default: eng_ack = 1'b1;
                endcase
                eng_done = 1'b1;
                @(negedge clk);
                eng_done = 1'b0;
            end
        end
    end

    function automatic logic [7:0] stat_exp(input logic busy, input logic pend, input logic nak);
        return {2'b00, busy, 1'b0, 2'b00, pend, nak};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic acc(input logic wr, input logic [2:0] a, input logic [15:0] d,
                       output logic [15:0] rd, output int cyc);
        logic got;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
        cyc = 0;
        got = 1'b0;
        do begin
            #2;
            got = bus_ready;
            rd  = bus_rdata;
            cyc++;
            @(posedge clk);
            if (!got) @(negedge clk);
        end while (!got);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        logic [15:0] rd; int c;
        acc(1'b1, a, d, rd, c);
    endtask

    task automatic rdchk(input string req, input logic [2:0] a, input logic [7:0] exp);
        logic [15:0] rd; int c;
        acc(1'b0, a, 16'h0, rd, c);
        chk(req, rd, {8'h00, exp});
    endtask

    task automatic finish_up();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_up();
    end

    initial begin
        logic [15:0] rd;
        int cyc, n0, s0;
        logic exp_act, exp_pend, exp_nak;
        logic [7:0] exp_buf, b;
        void'($urandom(32'd7));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset values and unmapped offsets
        for (int i = 0; i < 8; i++) rdchk("R1 reset", 3'(i), 8'h00);
        chk("R6 irq at reset", {15'h0, irq}, 16'h0);
        wr(3'd0, 16'hAB57);
        rdchk("R1 own mask", 3'd0, 8'h56);
        wr(3'd1, 16'h12FF);
        rdchk("R1 divider mask", 3'd1, 8'h3F);
        wr(3'd6, 16'h00FF);
        rdchk("R1 unmapped write", 3'd6, 8'h00);

        // R2 R3 enable with interrupts, host mode
        wr(3'd2, 16'h00E3);
        rdchk("R2 ctrl bits", 3'd2, 8'hE0);
        rdchk("R3 busy set", 3'd3, stat_exp(1, 0, 0));

        // R9 address ack
        acc(1'b1, 3'd4, 16'h00A0, rd, cyc);
        chk("R9 start op", 16'(last_op), 16'd0);
        chk("R12 stall on engine", 16'(cyc > 1), 16'd1);
        rdchk("R9 ack status", 3'd3, stat_exp(1, 1, 0));
        chk("R6 irq high", {15'h0, irq}, 16'h1);

        // R7 write one keeps, write zero clears
        acc(1'b1, 3'd3, 16'h00FF, rd, cyc);
        chk("R12 plain access one cycle", 16'(cyc), 16'd1);
        rdchk("R7 write one no effect", 3'd3, stat_exp(1, 1, 0));
        wr(3'd3, 16'h0000);
        rdchk("R7 write zero clears", 3'd3, stat_exp(1, 0, 0));
        chk("R7 irq low", {15'h0, irq}, 16'h0);

        // R10 send ack, then refused byte
        wr(3'd4, 16'h0012);
        chk("R10 send op", 16'(last_op), 16'd1);
        rdchk("R10 ack status", 3'd3, stat_exp(1, 1, 0));
        wr(3'd3, 16'h0000);
        s0 = stop_cnt;
        wr(3'd4, 16'h00EE);
        chk("R10 nack ends", 16'(stop_cnt - s0), 16'd1);
        rdchk("R10 nack status", 3'd3, stat_exp(1, 0, 1));
        wr(3'd4, 16'h0033);
        chk("R10 target closed", 16'(last_op), 16'd0);
        rdchk("R9 address nack", 3'd3, stat_exp(1, 0, 1));

        // R6 interrupt enable off: no pending
        wr(3'd2, 16'h00A0);
        wr(3'd4, 16'h00A1);
        rdchk("R6 no pend without ie", 3'd3, stat_exp(1, 0, 0));
        chk("R6 irq stays low", {15'h0, irq}, 16'h0);

        // R11 prefetching reads
        rdchk("R11 read1", 3'd4, 8'hFF);
        chk("R11 recv op", 16'(last_op), 16'd2);
        rdchk("R11 read2", 3'd4, 8'h40);
        rx_fail = 1'b1;
        rdchk("R11 read3", 3'd4, 8'h41);
        rx_fail = 1'b0;
        rdchk("R11 failed fetch", 3'd4, 8'hFF);
        wr(3'd2, 16'h00B0);
        n0 = op_cnt;
        rdchk("R11 tx dir read", 3'd4, 8'h42);
        chk("R11 no request", 16'(op_cnt - n0), 16'd0);
        wr(3'd2, 16'h00A0);
        rdchk("R11 after tx dir", 3'd4, 8'hFF);

        // R4 repeated start
        s0 = stop_cnt;
        wr(3'd2, 16'h00A4);
        chk("R4 end issued", 16'(stop_cnt - s0), 16'd1);
        rdchk("R4 bit self clears", 3'd2, 8'hA0);
        wr(3'd2, 16'h00A4);
        rdchk("R4 kept without target", 3'd2, 8'hA4);
        wr(3'd2, 16'h00A0);

        // R3 host mode cleared with open target
        wr(3'd4, 16'h00A0);
        s0 = stop_cnt;
        wr(3'd2, 16'h0080);
        chk("R3 end issued", 16'(stop_cnt - s0), 16'd1);
        rdchk("R3 busy cleared", 3'd3, stat_exp(0, 0, 0));

        // R5 soft reset with open target
        wr(3'd2, 16'h00E0);
        wr(3'd4, 16'h00A0);
        chk("R6 pend before soft", {15'h0, irq}, 16'h1);
        s0 = stop_cnt;
        wr(3'd2, 16'h0000);
        chk("R5 end issued", 16'(stop_cnt - s0), 16'd1);
        chk("R5 irq cleared", {15'h0, irq}, 16'h0);
        rdchk("R5 own kept", 3'd0, 8'h56);
        rdchk("R5 divider", 3'd1, 8'h00);
        rdchk("R5 ctrl", 3'd2, 8'h00);
        rdchk("R5 status", 3'd3, 8'h00);
        rdchk("R5 read buffer", 3'd4, 8'h00);

        // R8 disabled data write
        n0 = op_cnt;
        wr(3'd4, 16'h00A0);
        chk("R8 no request", 16'(op_cnt - n0), 16'd0);
        rdchk("R8 status unchanged", 3'd3, 8'h00);
        wr(3'd2, 16'h0080);
        wr(3'd4, 16'h00A0);
        chk("R8 not host no request", 16'(op_cnt - n0), 16'd0);

        // Random mix of sends, reads and clears against a bench model
        wr(3'd2, 16'h00E0);
        exp_act = 1'b0; exp_pend = 1'b0; exp_nak = 1'b0; exp_buf = 8'hFF;
        for (int it = 0; it < 60; it++) begin
            if (!exp_act) begin
                wr(3'd4, 16'h00A0);
                exp_act = 1'b1; exp_nak = 1'b0; exp_pend = 1'b1;
            end
            case ($urandom % 3)
                0: begin
                    b = ($urandom % 4 == 0) ? 8'hEE : 8'($urandom);
                    wr(3'd4, {8'h00, b});
                    if (b == 8'hEE) begin
                        exp_nak = 1'b1; exp_act = 1'b0;
                    end else begin
                        exp_nak = 1'b0; exp_pend = 1'b1;
                    end
                    chk("R10 random send op", 16'(last_op), (b == 8'hEE) ? 16'd3 : 16'd1);
                end
                1: begin
                    rdchk("R11 random read", 3'd4, exp_buf);
                    exp_buf = rx_next - 8'd1;
                    exp_pend = 1'b1;
                end
                default: begin
                    wr(3'd3, 16'h0000);
                    exp_pend = 1'b0;
                end
            endcase
            rdchk("R6 random status", 3'd3, stat_exp(1, exp_pend, exp_nak));
            chk("R6 random irq", {15'h0, irq}, {15'h0, exp_pend});
        end

        finish_up();
    end
endmodule